// File: doc/BRIEF.md
# DMA Address and Count Register Unit

This unit holds the control registers that a CPU programs before a DMA engine moves a block of words. A transfer count register carries a 14-bit word count along with a run-enable flag and a direction flag. A DMA address register is loaded in an unusual way: the value does not come from the data bus. It is taken from the CPU address lines of the write cycle itself. Address bit 14 of that cycle selects whether the upper or the lower part of the DMA address is replaced.

The unit drives the current DMA address, count, enable and direction to the DMA engine. Each `xfer_step` pulse from the engine advances the address by one word and counts the transfer down. When the last word has been counted, the run-enable flag drops. The same register zone also contains a miscellaneous control register whose top bit turns a periodic timer on or off. This unit keeps the timer enable and its pending flag.

All pins are plain control and status signals. There is no streamed data path, so there is no valid/ready handshake and no back-pressure. A CPU write takes effect at the clock edge on which `cpu_wr` is sampled high. Read data is combinational from `cpu_addr`.

Top module: `dma_regs_unit`

## Requirements
- R1: After reset, the DMA address, count, enable, direction, timer enable and timer pending are all zero.
- R2: A word-size write (`cpu_size`=2'b01) with `cpu_addr[19:16]`=4'h6 sets the count to `cpu_wdata[13:0]` plus one, modulo 2^14. The same write sets direction from `cpu_wdata[14]` and enable from `cpu_wdata[15]`.
- R3: A write with `cpu_addr[19:16]`=4'h6 whose size is byte (2'b00) or long (2'b10) leaves count, enable and direction unchanged.
- R4: With `cpu_addr[19:16]`=4'h6, `cpu_rdata` is {2'b11, count}. With any other select value, `cpu_rdata` is 16'hFFFF.
- R5: A write with `cpu_addr[19:16]`=4'hD and `cpu_addr[14]`=1 loads DMA address bits 21:9 from `cpu_addr[13:1]`. DMA address bits 8:1 are kept.
- R6: A write with `cpu_addr[19:16]`=4'hD and `cpu_addr[14]`=0 loads DMA address bits 8:1 from `cpu_addr[8:1]`. DMA address bits 21:9 are kept.
- R7: DMA address bit 0 is always zero.
- R8: An `xfer_step` pulse while enable is set adds 2 to the DMA address (wrapping at 2^22) and subtracts one from the count (wrapping at 2^14).
- R9: Enable clears on the step that brings the count to zero. A step while enable is clear changes nothing.
- R10: When a CPU write and a step land in the same cycle, the written register takes the CPU value and the step has no effect on that register.
- R11: A write with `cpu_addr[19:16]`=4'hA sets timer enable from `cpu_wdata[15]`. When that bit is 0, the write also clears timer pending. A `timer_tick` while timer enable is set raises timer pending.
- R12: Writes with any select value other than 4'h6, 4'hD and 4'hA change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 20 | CPU address within the zone; bits 19:16 select the register |
| cpu_wdata | input | 16 | CPU write data |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| cpu_rdata | output | 16 | Read data for the selected register |
| xfer_step | input | 1 | One-word transfer done, from the DMA engine |
| timer_tick | input | 1 | Periodic timer event |
| dma_addr | output | 22 | Current DMA byte address |
| dma_count | output | 14 | Remaining word count |
| dma_en | output | 1 | DMA run enable |
| dma_dir | output | 1 | DMA direction flag |
| timer_en | output | 1 | Timer enable |
| timer_pend | output | 1 | Timer event pending |

## Verification
Two cases are the hardest to reach from the ports: a collision between a CPU write and a step in the same cycle, and the count running down to zero. Both depend on how the count was loaded, because the loaded value is the written value plus one. The bench therefore writes small data values and issues exactly that many steps plus one, confirming the enable drops on the final step. It also loads 0x3FFF, which wraps the count to zero, and confirms that stepping from zero wraps the count without touching enable. Collision cycles are driven by raising `xfer_step` in the same cycle as count and address writes.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_COUNT = 4'h6;
  localparam logic [SEL_W-1:0] SEL_MISC  = 4'hA;
  localparam logic [SEL_W-1:0] SEL_DADDR = 4'hD;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } acc_size_e;

  typedef struct packed {
    logic count;
    logic daddr;
    logic misc;
  } reg_sel_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int ZONE_AW = 20
) (
  input  logic [ZONE_AW-1:0] addr,
  input  logic               wr,
  output reg_sel_t           rsel,
  output reg_sel_t           wsel
);
  localparam int SEL_LSB = ZONE_AW - SEL_W;
  logic [SEL_W-1:0] code;

  always_comb begin
    code       = addr[ZONE_AW-1:SEL_LSB];
    rsel.count = (code == SEL_COUNT);
    rsel.daddr = (code == SEL_DADDR);
    rsel.misc  = (code == SEL_MISC);
    wsel.count = wr && rsel.count;
    wsel.daddr = wr && rsel.daddr;
    wsel.misc  = wr && rsel.misc;
  end
endmodule

// File: rtl/dma_count_ctr.sv
module dma_count_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [15:0]      wdata,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             en,
  output logic             dir
);
  localparam int EN_BIT  = 15;
  localparam int DIR_BIT = 14;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      en    <= 1'b0;
      dir   <= 1'b0;
    end else if (load) begin
      count <= wdata[CNT_W-1:0] + ONE;
      dir   <= wdata[DIR_BIT];
      en    <= wdata[EN_BIT];
    end else if (step && en) begin
      count <= count - ONE;
      if (count == ONE) en <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int ADDR_W  = 22,
  parameter int SPLIT   = 9,
  parameter int BANK_BIT = 14,
  parameter int ZONE_AW = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ZONE_AW-1:0] cpu_addr,
  input  logic               step,
  output logic [ADDR_W-1:0]  dma_addr
);
  localparam int HI_W = ADDR_W - SPLIT;
  localparam int LO_W = SPLIT - 1;
  logic [ADDR_W-1:1] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      if (cpu_addr[BANK_BIT])
        word_q[ADDR_W-1:SPLIT] <= cpu_addr[HI_W:1];
      else
        word_q[SPLIT-1:1] <= cpu_addr[LO_W:1];
    end else if (step) begin
      word_q <= word_q + 1'b1;
    end
  end

  assign dma_addr = {word_q, 1'b0};
endmodule

// File: rtl/dma_regs_unit.sv
module dma_regs_unit
  import dma_regs_pkg::*;
#(
  parameter int ZONE_AW = 20,
  parameter int ADDR_W  = 22,
  parameter int CNT_W   = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [ZONE_AW-1:0] cpu_addr,
  input  logic [15:0]        cpu_wdata,
  input  logic [1:0]         cpu_size,
  output logic [15:0]        cpu_rdata,
  input  logic               xfer_step,
  input  logic               timer_tick,
  output logic [ADDR_W-1:0]  dma_addr,
  output logic [CNT_W-1:0]   dma_count,
  output logic               dma_en,
  output logic               dma_dir,
  output logic               timer_en,
  output logic               timer_pend
);
  localparam int PAD_W = 16 - CNT_W;
  reg_sel_t rsel, wsel;
  logic     cnt_load, step_ok;

  dma_reg_decode #(.ZONE_AW(ZONE_AW)) u_dec (
    .addr(cpu_addr), .wr(cpu_wr), .rsel(rsel), .wsel(wsel)
  );

  assign cnt_load = wsel.count && (cpu_size == SZ_WORD);
  assign step_ok  = xfer_step && dma_en;

  dma_count_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .wdata(cpu_wdata),
    .step(xfer_step), .count(dma_count), .en(dma_en), .dir(dma_dir)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W), .SPLIT(9), .BANK_BIT(14), .ZONE_AW(ZONE_AW)) u_adr (
    .clk(clk), .rst_n(rst_n), .load(wsel.daddr), .cpu_addr(cpu_addr),
    .step(step_ok), .dma_addr(dma_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_en   <= 1'b0;
      timer_pend <= 1'b0;
    end else begin
      if (wsel.misc) timer_en <= cpu_wdata[15];
      if (wsel.misc && !cpu_wdata[15]) timer_pend <= 1'b0;
      else if (timer_en && timer_tick) timer_pend <= 1'b1;
    end
  end

  always_comb begin
    if (rsel.count) cpu_rdata = {{PAD_W{1'b1}}, dma_count};
    else            cpu_rdata = 16'hFFFF;
  end
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [19:0] cpu_addr,
  input logic [15:0] cpu_wdata,
  input logic [1:0]  cpu_size,
  input logic [15:0] cpu_rdata,
  input logic        xfer_step,
  input logic [21:0] dma_addr,
  input logic [13:0] dma_count,
  input logic        dma_en,
  input logic        timer_en,
  input logic        timer_pend
);
  logic cw, aw, mw;
  assign cw = cpu_wr && cpu_addr[19:16] == 4'h6 && cpu_size == 2'b01;
  assign aw = cpu_wr && cpu_addr[19:16] == 4'hD;
  assign mw = cpu_wr && cpu_addr[19:16] == 4'hA;

  p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> dma_count == $past(cpu_wdata[13:0]) + 14'd1);

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[19:16] == 4'h6 && cpu_size != 2'b01 && !xfer_step)
    |=> $stable(dma_count) && $stable(dma_en));

  p_count_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[19:16] == 4'h6 |-> cpu_rdata[15:14] == 2'b11);

  p_addr_hi_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (aw && cpu_addr[14]) |=> dma_addr[8:1] == $past(dma_addr[8:1]));

  p_addr_lo_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (aw && !cpu_addr[14]) |=> dma_addr[21:9] == $past(dma_addr[21:9]));

  p_step_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_step && dma_en && !aw) |=> dma_addr == $past(dma_addr) + 22'd2);

  p_last_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_step && dma_en && dma_count == 14'd1 && !cw) |=> !dma_en && dma_count == 14'd0);

  p_idle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_step && !dma_en && !cpu_wr) |=> $stable(dma_count) && $stable(dma_addr));

  p_timer_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mw && !cpu_wdata[15]) |=> !timer_en && !timer_pend);
endmodule

bind dma_regs_unit dma_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_size(cpu_size), .cpu_rdata(cpu_rdata),
  .xfer_step(xfer_step), .dma_addr(dma_addr), .dma_count(dma_count),
  .dma_en(dma_en), .timer_en(timer_en), .timer_pend(timer_pend)
);

// File: tb/sim_dma_regs_unit.sv
`timescale 1ns/1ps
module sim_dma_regs_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 1'b0, xfer_step = 1'b0, timer_tick = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [1:0]  cpu_size = 2'b01;
  logic [15:0] cpu_rdata;
  logic [21:0] dma_addr;
  logic [13:0] dma_count;
  logic dma_en, dma_dir, timer_en, timer_pend;

  int n_chk = 0, n_fail = 0;
  logic [13:0] m_cnt = '0;
  logic [21:0] m_addr = '0;
  logic m_en = 0, m_dir = 0, m_ten = 0, m_tp = 0;

  always #5 clk = ~clk;

  dma_regs_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " count"}, 32'(dma_count), 32'(m_cnt));
    chk({req, " en"},    32'(dma_en),    32'(m_en));
    chk({req, " dir"},   32'(dma_dir),   32'(m_dir));
    chk({req, " addr"},  32'(dma_addr),  32'(m_addr));
    chk({req, " tmr"},   32'({timer_en, timer_pend}), 32'({m_ten, m_tp}));
    chk("R7 addr bit0",  32'(dma_addr[0]), 32'(0));
  endtask

  task automatic op(input string req, input logic wr, input logic [19:0] a,
                    input logic [15:0] d, input logic [1:0] sz,
                    input logic st, input logic tk);
    logic stp;
    @(negedge clk);
    cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_size = sz;
    xfer_step = st; timer_tick = tk;
    @(posedge clk);
    stp = st && m_en;
    if (wr && a[19:16] == 4'hD) begin
      if (a[14]) m_addr[21:9] = a[13:1];
      else       m_addr[8:1]  = a[8:1];
    end else if (stp) m_addr = m_addr + 22'd2;
    if (wr && a[19:16] == 4'h6 && sz == 2'b01) begin
      m_cnt = d[13:0] + 14'd1; m_dir = d[14]; m_en = d[15];
    end else if (stp) begin
      m_cnt = m_cnt - 14'd1;
      if (m_cnt == 0) m_en = 1'b0;
    end
    if (wr && a[19:16] == 4'hA && !d[15]) m_tp = 1'b0;
    else if (m_ten && tk) m_tp = 1'b1;
    if (wr && a[19:16] == 4'hA) m_ten = d[15];
    #2;
    cpu_wr = 0; xfer_step = 0; timer_tick = 0;
    chk_all(req);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 chk_all("R1 reset");
    @(negedge clk) rst_n = 1'b1;

    // R2: word writes over walking and patterned data
    for (int i = 0; i < 16; i++) begin
      op("R2 load", 1, 20'h60000, 16'(1 << i), 2'b01, 0, 0);
      op("R2 load", 1, 20'h60000, ~16'(1 << i), 2'b01, 0, 0);
    end
    op("R2 wrap", 1, 20'h60000, 16'h3FFF, 2'b01, 0, 0);
    // R3: non-word sizes ignored
    op("R3 byte", 1, 20'h60000, 16'hC123, 2'b00, 0, 0);
    op("R3 long", 1, 20'h60000, 16'h8456, 2'b10, 0, 0);
    // R4: read back
    for (int s = 0; s < 16; s++) begin
      @(negedge clk) cpu_addr = {4'(s), 16'h0000};
      #2 chk("R4 read", 32'(cpu_rdata), (s == 6) ? 32'({2'b11, m_cnt}) : 32'hFFFF);
    end
    // R5/R6: address loads from address lines
    for (int i = 1; i < 14; i++)
      op("R5 hi", 1, 20'hD4000 | 20'(1 << i), 16'hFFFF, 2'b01, 0, 0);
    for (int i = 1; i < 9; i++)
      op("R6 lo", 1, 20'hD0000 | 20'(1 << i) | 20'h0201, 16'h0000, 2'b00, 0, 0);
    op("R5 hi all", 1, 20'hD7FFF, 16'h0, 2'b01, 0, 0);
    op("R6 lo all", 1, 20'hD01FF, 16'h0, 2'b01, 0, 0);
    // R8/R9: run counts down to zero, address wraps at top
    for (int n = 0; n < 6; n++) begin
      op("R2 arm", 1, 20'h60000, 16'h8000 | 16'(n), 2'b01, 0, 0);
      for (int k = 0; k <= n + 1; k++) op("R8 R9 step", 0, 20'h0, 16'h0, 2'b01, 1, 0);
    end
    op("R9 idle step", 0, 20'h0, 16'h0, 2'b01, 1, 0);
    op("R2 arm zero", 1, 20'h60000, 16'hFFFF, 2'b01, 0, 0);
    op("R9 from zero", 0, 20'h0, 16'h0, 2'b01, 1, 0);
    // R10: collisions
    op("R10 cnt wr", 1, 20'h60000, 16'h8010, 2'b01, 1, 0);
    op("R10 addr wr", 1, 20'hD0106, 16'h0, 2'b01, 1, 0);
    op("R10 addr wr hi", 1, 20'hD4ABC, 16'h0, 2'b01, 1, 0);
    op("R8 step", 0, 20'h0, 16'h0, 2'b01, 1, 0);
    // R11: timer
    op("R11 tick off", 0, 20'h0, 16'h0, 2'b01, 0, 1);
    op("R11 on", 1, 20'hA0000, 16'h8000, 2'b01, 0, 1);
    op("R11 tick", 0, 20'h0, 16'h0, 2'b01, 0, 1);
    op("R11 keep", 1, 20'hA0000, 16'h8000, 2'b01, 0, 0);
    op("R11 off", 1, 20'hA0000, 16'h7FFF, 2'b01, 0, 1);
    // R12: other selects change nothing
    for (int s = 0; s < 16; s++)
      if (s != 6 && s != 10 && s != 13)
        op("R12 other", 1, {4'(s), 16'h7FFE}, 16'hFFFF, 2'b01, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule